// File: doc/BRIEF.md
# Keyboard Character Buffer

This block is a memory-mapped input peripheral that collects key codes into a small first-in first-out store and lets a processor read and steer that store through four word-aligned registers. A key source presents an 8-bit ASCII code together with a one-cycle valid strobe. A processor reaches the block through a simple bus slave made of an address, read and write strobes, 32-bit write data and 32-bit read data.

Software polls a readiness bit, reads the oldest buffered character and then issues a consume command to retire it. A separate register always shows the most recent key, whether or not the store had room for it. Two further commands empty the store, or empty it and also forget the most recent key. Read data is combinational: it is valid in the same cycle as the read strobe. Commands and key strobes take effect at the next rising clock edge.

Top module: `kbd_char_buffer`

## Requirements
- R1: After the reset input has been high for a clock edge, reads of offsets 0x00, 0x04 and 0x08 all return 0.
- R2: A read of offset 0x00 returns the oldest buffered character in bits 7:0, with bits 31:8 zero. Characters leave the store in arrival order. When the store is empty, the read returns 0.
- R3: A read of offset 0x04 returns 1 when two or more characters are buffered, and 0 otherwise.
- R4: A read of offset 0x08 returns the code of the latest key strobe, zero-extended. It also updates when that key could not be stored.
- R5: Writing value 1 to offset 0x0C removes the oldest character. On an empty store it has no effect.
- R6: Writing value 2 to offset 0x0C empties the store and leaves the most-recent-key register unchanged.
- R7: Writing value 3 to offset 0x0C empties the store and clears the most-recent-key register to 0.
- R8: The store holds 16 characters. A key that arrives while it is full, without a consume in the same cycle, is dropped, and the stored contents stay as they were.
- R9: A key strobe in the same cycle as a consume command removes the oldest character and appends the new one, so the count does not change. This also holds when the store is full.
- R10: Reads of offset 0x0C, of any other offset, and any cycle with the read strobe low return 0.
- R11: Writes to offsets other than 0x0C, and writes to 0x0C with any value other than 1, 2 or 3, change no state.
- R12: A key strobe in the same cycle as command 2 or 3 is not stored. With command 2 it becomes the most recent key. With command 3 the most-recent-key register reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| key_code | input | 8 | ASCII code of the incoming key |
| key_valid | input | 1 | One-cycle strobe qualifying key_code |
| bus_addr | input | 12 | Byte offset into the register window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading a mapped status register |

## Verification
The store is swept through every fill level from empty to past full, using arithmetic character sequences. At each level the head, readiness and most-recent reads are compared with a bench queue model. This separates correct ordering from a stuck or skipped pointer, and it places the readiness threshold exactly at two. Consume, clear and reset commands are then issued at several fill levels, alone and in the same cycle as a key strobe. This distinguishes the simultaneous-push-and-pop rule, including at full, from a design that lets one of the two win. A sweep of non-command write values and unmapped read offsets shows that decoding is exact and not partial.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    localparam int KB_DATA_W = 32;
    localparam int KB_CHAR_W = 8;

    // Register window byte offsets (word aligned)
    localparam logic [7:0] OFS_HEAD  = 8'h00;
    localparam logic [7:0] OFS_READY = 8'h04;
    localparam logic [7:0] OFS_LAST  = 8'h08;
    localparam logic [7:0] OFS_CMD   = 8'h0C;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_POP   = 2'd1,
        CMD_FLUSH = 2'd2,
        CMD_RESET = 2'd3
    } kb_cmd_e;

    typedef struct packed {
        logic pop;
        logic flush;
        logic wipe_last;
    } kb_ctl_t;

    function automatic kb_cmd_e decode_cmd(input logic [KB_DATA_W-1:0] v);
        kb_cmd_e c;
        case (v)
            32'd1:   c = CMD_POP;
            32'd2:   c = CMD_FLUSH;
            32'd3:   c = CMD_RESET;
            default: c = CMD_NONE;
        endcase
        return c;
    endfunction

    function automatic kb_ctl_t cmd_to_ctl(input kb_cmd_e c);
        kb_ctl_t t;
        t.pop       = (c == CMD_POP);
        t.flush     = (c == CMD_FLUSH) || (c == CMD_RESET);
        t.wipe_last = (c == CMD_RESET);
        return t;
    endfunction

endpackage

// File: rtl/kbd_fifo.sv
module kbd_fifo
    import kbd_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    input  logic             flush,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             pop_ok, push_ok, is_full, is_empty;

    assign is_empty = (count == '0);
    assign is_full  = (count == CNT_W'(DEPTH));
    assign pop_ok   = pop_req && !is_empty && !flush;
    assign push_ok  = push_req && !flush && (!is_full || pop_ok);

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            if (push_ok) wr_ptr <= bump(wr_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    assign head = is_empty ? '0 : mem[rd_ptr];

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_full_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (is_full && push_req && !pop_req && !flush) |=> (count == CNT_W'(DEPTH)));

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

    assert_pop_empty_noop_R5: assert property (@(posedge clk) disable iff (rst)
        (is_empty && pop_req && !push_req && !flush) |=> (count == '0));

    assert_push_pop_level_R9: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && !is_empty && !flush) |=> $stable(count));

endmodule

// File: rtl/kbd_bus_decode.sv
module kbd_bus_decode
    import kbd_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [KB_DATA_W-1:0] bus_wdata,
    input  logic [KB_CHAR_W-1:0] head_char,
    input  logic                 ready_bit,
    input  logic [KB_CHAR_W-1:0] last_char,
    output kb_ctl_t              ctl,
    output logic [KB_DATA_W-1:0] bus_rdata
);

    logic hit_head, hit_ready, hit_last, hit_cmd;

    assign hit_head  = (bus_addr == ADDR_W'(OFS_HEAD));
    assign hit_ready = (bus_addr == ADDR_W'(OFS_READY));
    assign hit_last  = (bus_addr == ADDR_W'(OFS_LAST));
    assign hit_cmd   = (bus_addr == ADDR_W'(OFS_CMD));

    always_comb begin
        ctl = cmd_to_ctl(CMD_NONE);
        if (bus_wr && hit_cmd) ctl = cmd_to_ctl(decode_cmd(bus_wdata));
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_head)       bus_rdata = {{(KB_DATA_W-KB_CHAR_W){1'b0}}, head_char};
            else if (hit_ready) bus_rdata = {{(KB_DATA_W-1){1'b0}}, ready_bit};
            else if (hit_last)  bus_rdata = {{(KB_DATA_W-KB_CHAR_W){1'b0}}, last_char};
        end
    end

    always_comb begin
        assert_rdata_quiet_R10: assert (bus_rd || bus_rdata == '0);
        assert_ctl_exclusive_R11: assert (!(ctl.pop && ctl.flush));
    end

endmodule

// File: rtl/kbd_char_buffer.sv
module kbd_char_buffer
    import kbd_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 12,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           key_code,
    input  logic                 key_valid,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata
);

    kb_ctl_t              ctl;
    logic [KB_CHAR_W-1:0] head_char;
    logic [KB_CHAR_W-1:0] last_char;
    logic [CNT_W-1:0]     fill;
    logic                 ready_bit;

    assign ready_bit = (fill >= CNT_W'(2));

    kbd_fifo #(.DEPTH(DEPTH), .WIDTH(KB_CHAR_W)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push_req (key_valid),
        .push_data(key_code),
        .pop_req  (ctl.pop),
        .flush    (ctl.flush),
        .head     (head_char),
        .count    (fill)
    );

    kbd_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .head_char(head_char),
        .ready_bit(ready_bit),
        .last_char(last_char),
        .ctl      (ctl),
        .bus_rdata(bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst || ctl.wipe_last) last_char <= '0;
        else if (key_valid)       last_char <= key_code;
    end

    assert_wipe_last_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.wipe_last |=> (last_char == '0));

    assert_last_follows_key_R4: assert property (@(posedge clk) disable iff (rst)
        (key_valid && !ctl.wipe_last) |=> (last_char == $past(key_code)));

endmodule

// File: tb/tb_kbd_char_buffer.sv
module tb_kbd_char_buffer;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  key_code;
    logic        key_valid;
    logic [11:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] q[$];
    logic [7:0] m_last;

    always #10 clk = ~clk;

    kbd_char_buffer dut (
        .clk(clk), .rst(rst), .key_code(key_code), .key_valid(key_valid),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 v = bus_rdata;
        bus_rd = 1'b0; bus_addr = '0;
    endtask

    // one clock edge with given stimulus; model updated per requirements
    task automatic op(input bit kv, input logic [7:0] kc, input bit wr,
                      input logic [11:0] a, input logic [31:0] wd);
        bit is_cmd;
        @(negedge clk);
        key_valid = kv; key_code = kc; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        key_valid = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        is_cmd = wr && (a == 12'h00C);
        if (is_cmd && wd == 32'd3) begin
            q.delete(); m_last = 8'h00;
        end else if (is_cmd && wd == 32'd2) begin
            q.delete(); if (kv) m_last = kc;
        end else begin
            if (is_cmd && wd == 32'd1 && q.size() > 0) void'(q.pop_front());
            if (kv) begin
                if (q.size() < DEPTH) q.push_back(kc);
                m_last = kc;
            end
        end
    endtask

    task automatic check_state(input string tag);
        logic [31:0] v;
        rd(12'h000, v); chk({tag, " R2 head"}, v, (q.size() > 0) ? {24'h0, q[0]} : 32'h0);
        rd(12'h004, v); chk({tag, " R3 ready"}, v, (q.size() >= 2) ? 32'd1 : 32'd0);
        rd(12'h008, v); chk({tag, " R4 last"}, v, {24'h0, m_last});
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1; key_valid = 0; key_code = 0; bus_rd = 0; bus_wr = 0;
        bus_addr = 0; bus_wdata = 0; m_last = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset state
        rd(12'h000, v); chk("R1 head", v, 0);
        rd(12'h004, v); chk("R1 ready", v, 0);
        rd(12'h008, v); chk("R1 last", v, 0);

        // R2 R3 R4 R8 fill sweep past full
        for (int i = 0; i < DEPTH + 3; i++) begin
            op(1, 8'h30 + 8'(i * 3), 0, 0, 0);
            check_state("fill");
        end
        // R2 R5 drain sweep, then consume on empty
        for (int i = 0; i < DEPTH + 2; i++) begin
            op(0, 0, 1, 12'h00C, 32'd1);
            check_state("R5 drain");
        end

        // R9 push with consume at several levels, including full
        for (int lvl = 0; lvl <= DEPTH; lvl += 4) begin
            op(0, 0, 1, 12'h00C, 32'd2);
            for (int i = 0; i < lvl; i++) op(1, 8'h61 + 8'(i), 0, 0, 0);
            op(1, 8'hA0 + 8'(lvl), 1, 12'h00C, 32'd1);
            check_state("R9 swap");
            for (int i = 0; i < lvl; i++) begin
                op(0, 0, 1, 12'h00C, 32'd1);
                check_state("R9 order");
            end
        end

        // R6 clear keeps last; R12 key with clear
        for (int i = 0; i < 5; i++) op(1, 8'h41 + 8'(i), 0, 0, 0);
        op(0, 0, 1, 12'h00C, 32'd2);
        check_state("R6 clear");
        for (int i = 0; i < 3; i++) op(1, 8'h51 + 8'(i), 0, 0, 0);
        op(1, 8'h7A, 1, 12'h00C, 32'd2);
        check_state("R12 clear+key");

        // R7 reset command; R12 key with reset
        for (int i = 0; i < 4; i++) op(1, 8'h21 + 8'(i), 0, 0, 0);
        op(0, 0, 1, 12'h00C, 32'd3);
        check_state("R7 reset cmd");
        op(1, 8'h44, 0, 0, 0);
        op(1, 8'h55, 1, 12'h00C, 32'd3);
        check_state("R12 reset+key");

        // R11 ignored writes
        for (int i = 0; i < 3; i++) op(1, 8'h6B + 8'(i), 0, 0, 0);
        op(0, 0, 1, 12'h000, 32'd1);
        op(0, 0, 1, 12'h004, 32'd2);
        op(0, 0, 1, 12'h008, 32'd3);
        op(0, 0, 1, 12'h01C, 32'd3);
        op(0, 0, 1, 12'h00C, 32'd0);
        op(0, 0, 1, 12'h00C, 32'd4);
        op(0, 0, 1, 12'h00C, 32'h101);
        op(0, 0, 1, 12'h00C, 32'hFFFF_FFFF);
        check_state("R11 ignored");

        // R10 control and unmapped reads, read strobe low
        begin
            logic [11:0] offs [8] = '{12'h00C, 12'h010, 12'h001, 12'h005,
                                      12'h00A, 12'h100, 12'hFFC, 12'h800};
            for (int i = 0; i < 8; i++) begin
                rd(offs[i], v); chk("R10 unmapped", v, 0);
            end
            @(negedge clk); bus_addr = 12'h008; bus_rd = 0;
            #2 chk("R10 rd low", bus_rdata, 0);
            bus_addr = 0;
        end

        // R1 external reset wipes everything
        @(negedge clk) rst = 1;
        @(negedge clk) rst = 0;
        q.delete(); m_last = 0;
        check_state("R1 after rst");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule